// File: doc/BRIEF.md
# Vertical Pattern Repetition Sequencer

This block steers one sweep region of a vertical clock timing generator. Within the region it issues one repetition of the base vertical pattern (group A) per line, and counts the repetitions from 1. For any repetition number picked by a per-group index, it swaps in a special pattern from group B, C or D. Each of the three special groups has its own enable bit. The downstream waveform generator reads the pattern-select code and the repetition number, and produces the actual clock edges. All special groups share the start offset of the base pattern, so the only thing that changes is which pattern plays.

The settings are captured only on the frame sync pulse, so they hold steady for a whole frame. The line sync pulse moves the line counter forward and, inside the region, the repetition counter too. Once the count reaches the programmed total, the block holds it and plays group A until the region ends.

Top module: `vpat_rep_seq`

## Requirements
- R1: After reset, `pat_sel` is 0, `rep_num` is 0 and `region_act` is 0.
- R2: The start and end lines, the total, the enables and the indices are taken in only in a cycle where `vd` is high. Changes on those inputs at other times have no effect on the outputs.
- R3: A `vd` pulse clears the line count and `rep_num` to 0 in the next cycle. `vd` wins over a coincident `hd`.
- R4: The line count is the number of `hd` pulses since the last `vd`. `region_act` is high exactly while that count lies within [start, end]. A start line of 0 never activates the region.
- R5: On the line equal to the start line, `rep_num` becomes 1. Each further `hd` inside the region adds 1.
- R6: Once `rep_num` equals the total N, later lines in the region keep `rep_num` at N and select group A. After the end line, `rep_num` holds its last value.
- R7: `pat_sel` encodes 0=A, 1=B, 2=C, 3=D. Enable bit 0 controls B, bit 1 controls C and bit 2 controls D. An enabled group whose index equals the current `rep_num` is selected for that repetition.
- R8: When several enabled groups match the same repetition, B wins over C and C wins over D.
- R9: An index of 0, or an index above N, never causes an insertion.
- R10: `pat_sel` is 0 whenever `region_act` is low.
- R11: With N equal to 0, `rep_num` stays 0 and group A is selected throughout the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vd | input | 1 | Frame sync pulse, one cycle |
| hd | input | 1 | Line sync pulse, one cycle |
| cfg_first_line | input | LINE_W | Line at which the sweep region starts |
| cfg_last_line | input | LINE_W | Last line of the sweep region |
| cfg_total | input | REP_W | Total repetitions N |
| cfg_grp_en | input | 3 | Special-group enables (bit 0 = B, bit 1 = C, bit 2 = D) |
| cfg_idx_b | input | REP_W | Repetition number replaced by group B |
| cfg_idx_c | input | REP_W | Repetition number replaced by group C |
| cfg_idx_d | input | REP_W | Repetition number replaced by group D |
| pat_sel | output | 2 | Pattern to play: 0=A, 1=B, 2=C, 3=D |
| rep_num | output | REP_W | Current repetition number |
| region_act | output | 1 | High on lines inside the sweep region |

## Verification
The bench builds the block with an 8-bit line count and a 4-bit repetition count. With these sizes a region whose total lies between 0 and 6 can be walked to its end in a few dozen line pulses. This makes the saturation point, indices above the total and regions past their last line cheap to reach. The same narrow width also lets a three-way index tie be set up in a single frame, so the priority order can be checked against every pairing of groups.

// File: rtl/vpat_pkg.sv
package vpat_pkg;

  typedef enum logic [1:0] {
    PAT_A = 2'd0,
    PAT_B = 2'd1,
    PAT_C = 2'd2,
    PAT_D = 2'd3
  } pat_e;

  localparam int NUM_SPC = 3;

  // An enabled special index fires only when nonzero, not above the total,
  // and equal to the current repetition.
  function automatic logic idx_fires(input logic en, input int unsigned idx,
                                     input int unsigned rep, input int unsigned total);
    return en && (idx != 0) && (idx <= total) && (idx == rep);
  endfunction

  // Count value loaded on the first line of the region.
  function automatic int unsigned first_rep(input int unsigned total);
    return (total != 0) ? 1 : 0;
  endfunction

  // Lowest group number among the hits wins; no hit selects the base group.
  function automatic pat_e pick_group(input logic [NUM_SPC-1:0] hits);
    pat_e r;
    r = PAT_A;
    for (int g = NUM_SPC - 1; g >= 0; g--) begin
      if (hits[g]) r = pat_e'(g + 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/vpat_cfg_shadow.sv
module vpat_cfg_shadow #(
  parameter int LINE_W = 12,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd,
  input  logic [LINE_W-1:0] in_first,
  input  logic [LINE_W-1:0] in_last,
  input  logic [REP_W-1:0]  in_total,
  input  logic [2:0]        in_en,
  input  logic [REP_W-1:0]  in_idx_b,
  input  logic [REP_W-1:0]  in_idx_c,
  input  logic [REP_W-1:0]  in_idx_d,
  output logic [LINE_W-1:0] first_q,
  output logic [LINE_W-1:0] last_q,
  output logic [REP_W-1:0]  total_q,
  output logic [2:0]        en_q,
  output logic [REP_W-1:0]  idx_q [3]
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      total_q <= '0;
      en_q    <= '0;
      idx_q[0] <= '0;
      idx_q[1] <= '0;
      idx_q[2] <= '0;
    end else if (vd) begin
      first_q <= in_first;
      last_q  <= in_last;
      total_q <= in_total;
      en_q    <= in_en;
      idx_q[0] <= in_idx_b;
      idx_q[1] <= in_idx_c;
      idx_q[2] <= in_idx_d;
    end
  end

endmodule

// File: rtl/vpat_line_tracker.sv
module vpat_line_tracker #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd,
  input  logic              hd,
  input  logic [LINE_W-1:0] first_line,
  input  logic [LINE_W-1:0] last_line,
  output logic [LINE_W-1:0] line_q,
  output logic              enter_ev,
  output logic              step_ev,
  output logic              in_region
);

  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_nx;
  logic              start_ok;
  logic              adv;

  assign line_nx  = (line_q == LINE_MAX) ? line_q : line_q + 1'b1;
  assign start_ok = (first_line != '0);
  assign adv      = hd && !vd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   line_q <= '0;
    else if (vd)  line_q <= '0;
    else if (hd)  line_q <= line_nx;
  end

  assign enter_ev  = adv && start_ok && (line_nx == first_line);
  assign step_ev   = adv && start_ok && (line_nx > first_line) && (line_nx <= last_line);
  assign in_region = start_ok && (line_q >= first_line) && (line_q <= last_line);

endmodule

// File: rtl/vpat_rep_counter.sv
module vpat_rep_counter #(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vd,
  input  logic             enter_ev,
  input  logic             step_ev,
  input  logic [REP_W-1:0] total,
  output logic [REP_W-1:0] rep_q,
  output logic             sat_q
);

  logic [REP_W-1:0] rep_init;
  assign rep_init = REP_W'(vpat_pkg::first_rep(int'(total)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q <= '0;
      sat_q <= 1'b0;
    end else if (vd) begin
      rep_q <= '0;
      sat_q <= 1'b0;
    end else if (enter_ev) begin
      rep_q <= rep_init;
      sat_q <= 1'b0;
    end else if (step_ev) begin
      if (rep_q >= total) sat_q <= 1'b1;
      else                rep_q <= rep_q + 1'b1;
    end
  end

endmodule

// File: rtl/vpat_pick.sv
module vpat_pick #(
  parameter int REP_W = 8
) (
  input  logic                         live,
  input  logic [REP_W-1:0]             rep,
  input  logic [REP_W-1:0]             total,
  input  logic [vpat_pkg::NUM_SPC-1:0] en,
  input  logic [REP_W-1:0]             idx [vpat_pkg::NUM_SPC],
  output logic [vpat_pkg::NUM_SPC-1:0] hits,
  output vpat_pkg::pat_e               sel
);

  for (genvar g = 0; g < vpat_pkg::NUM_SPC; g++) begin : g_grp
    assign hits[g] = vpat_pkg::idx_fires(en[g], int'(idx[g]), int'(rep), int'(total));
  end

  assign sel = live ? vpat_pkg::pick_group(hits) : vpat_pkg::PAT_A;

endmodule

// File: rtl/vpat_rep_seq.sv
module vpat_rep_seq #(
  parameter int LINE_W = 12,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vd,
  input  logic              hd,
  input  logic [LINE_W-1:0] cfg_first_line,
  input  logic [LINE_W-1:0] cfg_last_line,
  input  logic [REP_W-1:0]  cfg_total,
  input  logic [2:0]        cfg_grp_en,
  input  logic [REP_W-1:0]  cfg_idx_b,
  input  logic [REP_W-1:0]  cfg_idx_c,
  input  logic [REP_W-1:0]  cfg_idx_d,
  output logic [1:0]        pat_sel,
  output logic [REP_W-1:0]  rep_num,
  output logic              region_act
);

  logic [LINE_W-1:0] first_q, last_q, line_q;
  logic [REP_W-1:0]  lim_q;
  logic [2:0]        en_q;
  logic [REP_W-1:0]  idx_q [3];
  logic              enter_ev, step_ev, in_region;
  logic [REP_W-1:0]  rep_q;
  logic              sat_q;
  logic              live_w;
  logic [2:0]        hit_w;
  vpat_pkg::pat_e    sel_w;

  vpat_cfg_shadow #(.LINE_W(LINE_W), .REP_W(REP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .vd(vd),
    .in_first(cfg_first_line), .in_last(cfg_last_line), .in_total(cfg_total),
    .in_en(cfg_grp_en), .in_idx_b(cfg_idx_b), .in_idx_c(cfg_idx_c), .in_idx_d(cfg_idx_d),
    .first_q(first_q), .last_q(last_q), .total_q(lim_q), .en_q(en_q), .idx_q(idx_q)
  );

  vpat_line_tracker #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd),
    .first_line(first_q), .last_line(last_q),
    .line_q(line_q), .enter_ev(enter_ev), .step_ev(step_ev), .in_region(in_region)
  );

  vpat_rep_counter #(.REP_W(REP_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .vd(vd),
    .enter_ev(enter_ev), .step_ev(step_ev), .total(lim_q),
    .rep_q(rep_q), .sat_q(sat_q)
  );

  assign live_w = in_region && !sat_q && (rep_q != '0);

  vpat_pick #(.REP_W(REP_W)) u_pick (
    .live(live_w), .rep(rep_q), .total(lim_q), .en(en_q), .idx(idx_q),
    .hits(hit_w), .sel(sel_w)
  );

  assign pat_sel    = sel_w;
  assign rep_num    = rep_q;
  assign region_act = in_region;

endmodule

// File: rtl/vpat_rep_seq_chk.sv
module vpat_rep_seq_chk #(
  parameter int REP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vd,
  input logic             hd,
  input logic [1:0]       pat_sel,
  input logic [REP_W-1:0] rep_num,
  input logic             region_act,
  input logic [REP_W-1:0] rep_lim,
  input logic             sat,
  input logic [2:0]       hits
);

  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !region_act |-> pat_sel == 2'd0); // R10

  AST_VD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vd |=> rep_num == '0); // R3

  AST_REP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!vd && !hd) |=> $stable(rep_num)); // R5

  AST_REP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rep_num <= rep_lim); // R6

  AST_SAT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    sat |-> pat_sel == 2'd0); // R6

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vd |=> $stable(rep_lim)); // R2

  AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel == 2'd3) |-> (hits[1:0] == 2'b00)); // R8

  AST_SPC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel != 2'd0) |-> (rep_num != '0 && rep_num <= rep_lim)); // R9

endmodule

bind vpat_rep_seq vpat_rep_seq_chk #(.REP_W(REP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd),
  .pat_sel(pat_sel), .rep_num(rep_num), .region_act(region_act),
  .rep_lim(lim_q), .sat(sat_q), .hits(hit_w)
);

// File: tb/vpat_rep_seq_test.sv
module vpat_rep_seq_test;

  localparam int LW = 8;
  localparam int RW = 4;

  typedef struct packed {
    logic [LW-1:0] st;
    logic [LW-1:0] en_l;
    logic [RW-1:0] n;
    logic [2:0]    en;
    logic [RW-1:0] ib;
    logic [RW-1:0] ic;
    logic [RW-1:0] id;
    logic [7:0]    k;
    logic [1:0]    sel;
    logic [RW-1:0] rep;
    logic          act;
  } vec_t;

  localparam int NV = 20;
  // st, end, N, en, ib, ic, id, hd pulses, expected sel, rep, act
  localparam vec_t VT [NV] = '{
    '{2, 9, 5, 3'b001, 4, 0, 0,  1, 0, 0, 0},  // R4 before start
    '{2, 9, 5, 3'b001, 4, 0, 0,  2, 0, 1, 1},  // R5 first line
    '{2, 9, 5, 3'b001, 4, 0, 0,  5, 1, 4, 1},  // R7 B inserted
    '{2, 9, 5, 3'b001, 4, 0, 0,  6, 0, 5, 1},  // R5 count to N
    '{2, 9, 5, 3'b001, 4, 0, 0,  7, 0, 5, 1},  // R6 held at N
    '{2, 9, 5, 3'b001, 4, 0, 0, 10, 0, 5, 0},  // R6 R10 past end
    '{1, 20, 6, 3'b111, 3, 3, 3, 3, 1, 3, 1},  // R8 B over C,D
    '{1, 20, 6, 3'b110, 3, 3, 3, 3, 2, 3, 1},  // R8 C over D
    '{1, 20, 6, 3'b100, 0, 0, 2, 2, 3, 2, 1},  // R7 D
    '{1, 20, 6, 3'b010, 0, 6, 0, 6, 2, 6, 1},  // R7 C at last rep
    '{1, 20, 6, 3'b010, 0, 6, 0, 7, 0, 6, 1},  // R6 base after N
    '{1, 20, 6, 3'b001, 7, 0, 0, 6, 0, 6, 1},  // R9 index above N
    '{1, 20, 6, 3'b001, 0, 0, 0, 1, 0, 1, 1},  // R9 index zero
    '{1, 20, 6, 3'b000, 2, 2, 2, 2, 0, 2, 1},  // R7 all disabled
    '{1, 20, 6, 3'b110, 0, 4, 4, 4, 2, 4, 1},  // R8 tie C,D
    '{1, 20, 6, 3'b110, 0, 2, 5, 5, 3, 5, 1},  // R7 D at own index
    '{0, 5, 3, 3'b001, 1, 0, 0,  2, 0, 0, 0},  // R4 start line 0
    '{1, 5, 0, 3'b001, 1, 0, 0,  1, 0, 0, 1},  // R11 zero total
    '{3, 3, 4, 3'b001, 1, 0, 0,  3, 1, 1, 1},  // R5 one-line region
    '{3, 3, 4, 3'b001, 1, 0, 0,  4, 0, 1, 0}   // R4 after one-line region
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vd = 1'b0, hd = 1'b0;
  logic [LW-1:0] cfg_first_line = '0, cfg_last_line = '0;
  logic [RW-1:0] cfg_total = '0, cfg_idx_b = '0, cfg_idx_c = '0, cfg_idx_d = '0;
  logic [2:0]    cfg_grp_en = '0;
  logic [1:0]    pat_sel;
  logic [RW-1:0] rep_num;
  logic          region_act;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vpat_rep_seq #(.LINE_W(LW), .REP_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .vd(vd), .hd(hd),
    .cfg_first_line(cfg_first_line), .cfg_last_line(cfg_last_line),
    .cfg_total(cfg_total), .cfg_grp_en(cfg_grp_en),
    .cfg_idx_b(cfg_idx_b), .cfg_idx_c(cfg_idx_c), .cfg_idx_d(cfg_idx_d),
    .pat_sel(pat_sel), .rep_num(rep_num), .region_act(region_act)
  );

  task automatic check(input string tag, input logic [1:0] es, input logic [RW-1:0] er,
                       input logic ea);
    n_chk++;
    if (pat_sel !== es || rep_num !== er || region_act !== ea) begin
      n_bad++;
      $display("FAIL %s: sel=%0d rep=%0d act=%0d expected sel=%0d rep=%0d act=%0d",
               tag, pat_sel, rep_num, region_act, es, er, ea);
    end
  endtask

  task automatic set_cfg(input logic [LW-1:0] st, input logic [LW-1:0] el,
                         input logic [RW-1:0] n, input logic [2:0] en,
                         input logic [RW-1:0] ib, input logic [RW-1:0] ic,
                         input logic [RW-1:0] id);
    cfg_first_line = st; cfg_last_line = el; cfg_total = n;
    cfg_grp_en = en; cfg_idx_b = ib; cfg_idx_c = ic; cfg_idx_d = id;
  endtask

  task automatic pulse_vd();
    @(negedge clk); vd = 1'b1;
    @(negedge clk); vd = 1'b0;
  endtask

  task automatic pulse_hd(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); hd = 1'b1;
      @(negedge clk); hd = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 2'd0, 4'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 2'd0, 4'd0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      set_cfg(VT[v].st, VT[v].en_l, VT[v].n, VT[v].en, VT[v].ib, VT[v].ic, VT[v].id);
      pulse_vd();
      pulse_hd(int'(VT[v].k));
      check($sformatf("vector %0d", v), VT[v].sel, VT[v].rep, VT[v].act);
    end

    // R2: inputs changed mid-frame have no effect until the next vd
    set_cfg(2, 9, 5, 3'b001, 4, 0, 0);
    pulse_vd();
    pulse_hd(3);
    check("R5 mid region", 2'd0, 4'd2, 1'b1);
    set_cfg(1, 20, 1, 3'b111, 1, 1, 1);
    @(negedge clk);
    check("R2 change ignored now", 2'd0, 4'd2, 1'b1);
    pulse_hd(2);
    check("R2 old settings still used", 2'd1, 4'd4, 1'b1);

    // R3: vd clears counters and loads the new settings
    pulse_vd();
    check("R3 vd clears", 2'd0, 4'd0, 1'b0);
    pulse_hd(1);
    check("R2 new settings after vd", 2'd1, 4'd1, 1'b1);

    // R3: vd wins over a simultaneous hd
    pulse_hd(1);
    @(negedge clk); vd = 1'b1; hd = 1'b1;
    @(negedge clk); vd = 1'b0; hd = 1'b0;
    check("R3 vd beats hd", 2'd0, 4'd0, 1'b0);

    // R11: zero total keeps rep at 0 across the region
    set_cfg(1, 6, 0, 3'b111, 1, 2, 3);
    pulse_vd();
    pulse_hd(4);
    check("R11 zero total later line", 2'd0, 4'd0, 1'b1);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", 2'd0, 4'd0, 1'b0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule